// File: doc/BRIEF.md
# Loop predicate generator

This block runs the loop control of a vector loop that does not know its vector length in advance. A load strobe captures a signed starting index, a signed bound and an element-size code. One cycle later the block presents the index, a per-lane predicate and two condition flags. Lane k of the predicate is set while index plus k is still below the bound. The first-active flag tells a branch whether another iteration is due. The none-active flag tells it that no lane remains.

A step strobe advances the held index by the number of lanes that fit in the implemented vector, given the current element size. The predicate and flags are then recomputed against the same bound. The index add saturates at the largest signed 64-bit value. The lane comparison runs one bit wider than the index, so lanes past the top of the signed range read as outside the loop and never wrap round to active.

Top module: `loop_pred_gen`

## Requirements
- R1: One cycle after a load strobe, `idx_o` equals the `idx_in` value sampled on that edge, and the bound and element size sampled with it govern the outputs.
- R2: The lane count is `VL_BITS >> (3 + esize)`, with esize code 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit elements. Predicate bit k (bit 0 = lane 0) is 1 exactly when k is below the lane count and index + k < bound, both taken as signed 64-bit integers. All bits at or above the lane count are 0.
- R3: The sum index + k is formed without wrap-around, so lanes whose position would exceed 2^63-1 are 0.
- R4: One cycle after a step strobe with no load, `idx_o` grows by the lane count of the held element size, and the predicate and flags are recomputed from the new index and the held bound.
- R5: A step whose sum would exceed 2^63-1 leaves `idx_o` at 2^63-1, and a step never lowers the index.
- R6: `first_o` equals predicate bit 0. It is 0 whenever bound <= index.
- R7: `none_o` is 1 exactly when every predicate bit is 0.
- R8: When load and step are strobed together, the load wins and the step is dropped.
- R9: With neither strobe high, every output holds its value.
- R10: While reset is asserted and after it is released, the outputs read index 0, predicate 0, `first_o` 0 and `none_o` 1 until the first strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Capture index, bound and element size |
| step_i | input | 1 | Advance the index by the lane count |
| idx_in | input | IDX_W | Signed starting index |
| bound_in | input | IDX_W | Signed loop bound |
| esize_in | input | 2 | Element-size code (0:8, 1:16, 2:32, 3:64 bits) |
| pred_o | output | VL_BITS/8 | Per-lane active predicate, lane 0 in bit 0 |
| first_o | output | 1 | Lane 0 active |
| none_o | output | 1 | No lane active |
| idx_o | output | IDX_W | Current index |

## Verification
Every result (index, predicate, first-active and none-active) lands in a register on the same rising edge that samples a strobe. So every result is due exactly one clock after the strobe. The bench drives strobes on the falling edge, drops them at the next falling edge and compares all four outputs at that moment, half a period after the capturing edge. Hold behaviour is checked by sampling again after several idle falling edges. Because the internal reset release takes two edges, the first strobe comes only after several idle cycles.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  typedef enum logic [1:0] {
    ESZ_B8  = 2'd0,
    ESZ_B16 = 2'd1,
    ESZ_B32 = 2'd2,
    ESZ_B64 = 2'd3
  } esz_e;
endpackage

// File: rtl/lpg_lane_count.sv
module lpg_lane_count
  import lpg_pkg::*;
#(
  parameter int MAX_LANES = 32,
  parameter int CW        = $clog2(MAX_LANES) + 1
) (
  input  esz_e          esz,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(MAX_LANES) >> esz;
  end
endmodule

// File: rtl/lpg_sat_add.sv
module lpg_sat_add #(
  parameter int W  = 64,
  parameter int CW = 6
) (
  input  logic [W-1:0]  base,
  input  logic [CW-1:0] inc,
  output logic [W-1:0]  sum
);
  logic [W:0] wide;
  logic       ovf;

  always_comb begin
    wide = {base[W-1], base} + (W+1)'(inc);
    // increment is never negative, so only positive overflow can occur
    ovf  = wide[W] ^ wide[W-1];
    sum  = ovf ? {1'b0, {(W-1){1'b1}}} : wide[W-1:0];
  end
endmodule

// File: rtl/lpg_lane_cmp.sv
module lpg_lane_cmp #(
  parameter int W         = 64,
  parameter int MAX_LANES = 32,
  parameter int CW        = $clog2(MAX_LANES) + 1
) (
  input  logic [W-1:0]         idx,
  input  logic [W-1:0]         bound,
  input  logic [CW-1:0]        count,
  output logic [MAX_LANES-1:0] pred
);
  logic signed [W:0] bound_x;
  assign bound_x = $signed({bound[W-1], bound});

  for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
    logic signed [W:0] pos;
    logic              in_vec;
    assign pos    = $signed({idx[W-1], idx}) + $signed((W+1)'(k));
    assign in_vec = CW'(k) < count;
    assign pred[k] = in_vec && (pos < bound_x);
  end
endmodule

// File: rtl/loop_pred_gen.sv
module loop_pred_gen
  import lpg_pkg::*;
#(
  parameter  int VL_BITS   = 256,
  parameter  int IDX_W     = 64,
  localparam int MAX_LANES = VL_BITS / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 step_i,
  input  logic [IDX_W-1:0]     idx_in,
  input  logic [IDX_W-1:0]     bound_in,
  input  logic [1:0]           esize_in,
  output logic [MAX_LANES-1:0] pred_o,
  output logic                 first_o,
  output logic                 none_o,
  output logic [IDX_W-1:0]     idx_o
);
  localparam int CW = $clog2(MAX_LANES) + 1;

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // state
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [IDX_W-1:0]     bnd_q, bnd_d;
  esz_e                 esz_q, esz_d;
  logic [MAX_LANES-1:0] pred_q, pred_d;
  logic                 first_q, first_d;
  logic                 none_q, none_d;
  logic                 upd_en;

  logic [CW-1:0]    cnt_held;
  logic [CW-1:0]    cnt_next;
  logic [IDX_W-1:0] idx_stepped;

  lpg_lane_count #(.MAX_LANES(MAX_LANES), .CW(CW)) u_cnt_held (
    .esz   (esz_q),
    .count (cnt_held)
  );

  lpg_sat_add #(.W(IDX_W), .CW(CW)) u_step_add (
    .base (idx_q),
    .inc  (cnt_held),
    .sum  (idx_stepped)
  );

  lpg_lane_count #(.MAX_LANES(MAX_LANES), .CW(CW)) u_cnt_next (
    .esz   (esz_d),
    .count (cnt_next)
  );

  lpg_lane_cmp #(.W(IDX_W), .MAX_LANES(MAX_LANES), .CW(CW)) u_cmp (
    .idx   (idx_d),
    .bound (bnd_d),
    .count (cnt_next),
    .pred  (pred_d)
  );

  // next-state
  always_comb begin
    upd_en = load_i | step_i;
    if (load_i) begin
      idx_d = idx_in;
      bnd_d = bound_in;
      esz_d = esz_e'(esize_in);
    end else begin
      idx_d = idx_stepped;
      bnd_d = bnd_q;
      esz_d = esz_q;
    end
    first_d = pred_d[0];
    none_d  = ~|pred_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q   <= '0;
      bnd_q   <= '0;
      esz_q   <= ESZ_B64;
      pred_q  <= '0;
      first_q <= 1'b0;
      none_q  <= 1'b1;
    end else if (upd_en) begin
      idx_q   <= idx_d;
      bnd_q   <= bnd_d;
      esz_q   <= esz_d;
      pred_q  <= pred_d;
      first_q <= first_d;
      none_q  <= none_d;
    end
  end

  assign pred_o  = pred_q;
  assign first_o = first_q;
  assign none_o  = none_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
  parameter int MAX_LANES = 32,
  parameter int W         = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 load_i,
  input logic                 step_i,
  input logic [W-1:0]         idx_in,
  input logic [1:0]           esize_in,
  input logic [MAX_LANES-1:0] pred_o,
  input logic                 first_o,
  input logic                 none_o,
  input logic [W-1:0]         idx_o
);
  localparam int CW = $clog2(MAX_LANES) + 1;

  logic [1:0]           esz_seen;
  logic [CW-1:0]        lanes_seen;
  logic [MAX_LANES-1:0] pred_plus1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      esz_seen <= 2'd3;
    else if (load_i) esz_seen <= esize_in;
  end

  always_comb begin
    lanes_seen = CW'(MAX_LANES) >> esz_seen;
    pred_plus1 = pred_o + MAX_LANES'(1);
  end

  assert_load_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> idx_o == $past(idx_in));

  assert_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_o & pred_plus1) == '0);

  assert_lane_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_o >> lanes_seen) == '0);

  assert_no_decrease_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> $signed(idx_o) >= $signed($past(idx_o)));

  assert_first_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    first_o == pred_o[0]);

  assert_none_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    none_o == (pred_o == '0));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && step_i) |=> idx_o == $past(idx_in));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> ($stable(pred_o) && $stable(idx_o) &&
                              $stable(first_o) && $stable(none_o)));
endmodule

bind loop_pred_gen lpg_checker #(.MAX_LANES(MAX_LANES), .W(IDX_W)) u_lpg_checker (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .load_i   (load_i),
  .step_i   (step_i),
  .idx_in   (idx_in),
  .esize_in (esize_in),
  .pred_o   (pred_o),
  .first_o  (first_o),
  .none_o   (none_o),
  .idx_o    (idx_o)
);

// File: tb/test_loop_pred_gen.sv
module test_loop_pred_gen;
  localparam int VLB = 256;
  localparam int ML  = VLB / 8;
  localparam logic [63:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic          step_i = 1'b0;
  logic [63:0]   idx_in = '0;
  logic [63:0]   bound_in = '0;
  logic [1:0]    esize_in = '0;
  logic [ML-1:0] pred_o;
  logic          first_o, none_o;
  logic [63:0]   idx_o;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [63:0] m_idx = '0;
  logic [63:0] m_bnd = '0;
  logic [1:0]  m_esz = 2'd3;

  always #10 clk = ~clk;

  loop_pred_gen #(.VL_BITS(VLB), .IDX_W(64)) i_loop_pred_gen (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
    .idx_in(idx_in), .bound_in(bound_in), .esize_in(esize_in),
    .pred_o(pred_o), .first_o(first_o), .none_o(none_o), .idx_o(idx_o)
  );

  function automatic logic [ML-1:0] exp_pred(logic [63:0] i, logic [63:0] n, logic [1:0] e);
    logic [ML-1:0] r;
    int lanes;
    logic signed [65:0] a, b;
    lanes = ML >> (int'(e));
    r = '0;
    for (int k = 0; k < ML; k++) begin
      a = $signed({{2{i[63]}}, i}) + 66'(k);
      b = $signed({{2{n[63]}}, n});
      r[k] = (k < lanes) && (a < b);
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_step(logic [63:0] i, logic [1:0] e);
    logic signed [65:0] s;
    s = $signed({{2{i[63]}}, i}) + 66'(ML >> (int'(e)));
    if (s > $signed({2'b00, SMAX})) return SMAX;
    return s[63:0];
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    logic [ML-1:0] p;
    p = exp_pred(m_idx, m_bnd, m_esz);
    chk(req, "idx",   idx_o, m_idx);
    chk(req, "pred",  64'(pred_o), 64'(p));
    chk(req, "first", 64'(first_o), 64'(p[0]));
    chk(req, "none",  64'(none_o), 64'(p == '0));
  endtask

  task automatic strobe(logic ld, logic st, logic [63:0] i, logic [63:0] n, logic [1:0] e);
    @(negedge clk);
    load_i = ld; step_i = st; idx_in = i; bound_in = n; esize_in = e;
    if (ld) begin
      m_idx = i; m_bnd = n; m_esz = e;
    end else if (st) begin
      m_idx = exp_step(m_idx, m_esz);
    end
    @(negedge clk);
    load_i = 1'b0; step_i = 1'b0;
  endtask

  task automatic t_reset;
    // R10: values while held and after release
    chk("R10", "idx in reset", idx_o, 64'd0);
    chk("R10", "pred in reset", 64'(pred_o), 64'd0);
    chk("R10", "first in reset", 64'(first_o), 64'd0);
    chk("R10", "none in reset", 64'(none_o), 64'd1);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R10");
  endtask

  task automatic t_edge_lanes;
    // R2 R6: lanes at n-2..n+1 give T,T,F,F with 64-bit elements
    strobe(1'b1, 1'b0, 64'd98, 64'd100, 2'd3);
    chk_all("R2");
    chk("R2", "pred literal", 64'(pred_o), 64'h3);
    chk("R6", "first", 64'(first_o), 64'd1);
  endtask

  task automatic t_byte_lanes;
    // R1 R2: 8-bit elements, 32 lanes, bound 10
    strobe(1'b1, 1'b0, 64'd0, 64'd10, 2'd0);
    chk_all("R1");
    chk("R2", "pred literal", 64'(pred_o), 64'h3FF);
  endtask

  task automatic t_done;
    // R6 R7: bound at or below index
    strobe(1'b1, 1'b0, 64'd50, 64'd50, 2'd1);
    chk_all("R7");
    chk("R6", "first clear", 64'(first_o), 64'd0);
    chk("R7", "none set", 64'(none_o), 64'd1);
  endtask

  task automatic t_negative;
    // R2: negative index, 32-bit elements, all 8 lanes below bound 3
    strobe(1'b1, 1'b0, -64'sd5, 64'd3, 2'd2);
    chk_all("R2");
    chk("R2", "pred literal", 64'(pred_o), 64'hFF);
  endtask

  task automatic t_top_of_range;
    // R3: index just below signed maximum must not wrap
    strobe(1'b1, 1'b0, SMAX - 64'd1, SMAX, 2'd0);
    chk_all("R3");
    chk("R3", "pred literal", 64'(pred_o), 64'h1);
  endtask

  task automatic t_stepping;
    // R4: 8 lanes per step toward bound 20
    strobe(1'b1, 1'b0, 64'd0, 64'd20, 2'd2);
    chk_all("R4");
    strobe(1'b0, 1'b1, '0, '0, 2'd0);
    chk_all("R4");
    chk("R4", "idx after step", idx_o, 64'd8);
    strobe(1'b0, 1'b1, '0, '0, 2'd0);
    chk("R4", "pred tail", 64'(pred_o), 64'hF);
    strobe(1'b0, 1'b1, '0, '0, 2'd0);
    chk_all("R4");
    chk("R4", "idx 24", idx_o, 64'd24);
  endtask

  task automatic t_saturate;
    // R5: step past signed maximum sticks there
    strobe(1'b1, 1'b0, SMAX - 64'd3, SMAX, 2'd3);
    chk_all("R5");
    strobe(1'b0, 1'b1, '0, '0, 2'd0);
    chk_all("R5");
    chk("R5", "idx saturated", idx_o, SMAX);
    strobe(1'b0, 1'b1, '0, '0, 2'd0);
    chk("R5", "idx stays", idx_o, SMAX);
  endtask

  task automatic t_priority;
    // R8: load beats step on the same edge
    strobe(1'b1, 1'b0, 64'd0, 64'd40, 2'd1);
    strobe(1'b1, 1'b1, 64'd3, 64'd40, 2'd1);
    chk_all("R8");
    chk("R8", "idx loaded", idx_o, 64'd3);
  endtask

  task automatic t_hold;
    // R9: idle cycles leave every output unchanged
    strobe(1'b1, 1'b0, 64'd7, 64'd12, 2'd2);
    idx_in = 64'd999; bound_in = 64'd1; esize_in = 2'd0;
    repeat (3) @(negedge clk);
    chk_all("R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_edge_lanes();
    t_byte_lanes();
    t_done();
    t_negative();
    t_top_of_range();
    t_stepping();
    t_saturate();
    t_priority();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule